// File: doc/BRIEF.md
# Effective Address Generator

This block turns an operand specifier into a location. A processor front end presents an addressing-mode code, up to two register numbers, a signed displacement, the program counter and the operand size, and pulses `start`. The unit reads the register file through two combinational read ports, forms the effective address (or the immediate value, or the register number), and returns it on a registered output with a one-cycle `done` pulse. Fetching the operand itself is left to the caller.

Ten of the eleven modes finish in one cycle. In memory-indirect mode the unit raises a word read request carrying the displacement as the pointer location. It holds that request until the memory acknowledges, and then returns the fetched word as the address. The post-increment and pre-decrement modes also update the pointer register. They drive a write strobe carrying the new pointer in the same cycle as `done`. The step is scaled by operand size.

Top module: `eagen_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done`, `wb_en` and `mem_req` are 0 and `ea` is 0.
- R2: For every mode code except 4, a `start` accepted while no memory request is open gives `done`=1 in the following cycle only. A `start` issued while a memory request is open has no effect.
- R3: Mode 0 (immediate) returns the displacement, sign-extended, on `ea` with `kind`=1.
- R4: Mode 1 (register) returns the register number `ra`, zero-extended, on `ea` with `kind`=2.
- R5: Mode 2 (absolute) returns the sign-extended displacement as the address. Mode 3 (register indirect) returns the value of register `ra`. Both give `kind`=0.
- R6: Mode 5 gives disp+[ra]. Mode 6 gives [ra]+[rb]. Mode 7 gives disp+[ra]+[rb]. Sums wrap modulo 2^AW.
- R7: Mode 8 (PC-relative) gives `pc` + displacement. A negative displacement points below `pc` and a positive one points above it.
- R8: Wherever the displacement enters a result, bits AW-1 down to DW are copies of displacement bit DW-1.
- R9: Mode 9 (post-increment) returns [ra] as the address and writes back [ra]+step. The step is 1, 2 or 4 for `opsize` codes 0, 1 and 2; code 3 also steps by 4.
- R10: Mode 10 (pre-decrement) returns [ra]-step as the address and writes back that same value.
- R11: `wb_en` is 1 only in the `done` cycle of modes 9 and 10, with `wb_sel`=`ra`. It is 0 for all other modes.
- R12: Mode 4 (memory indirect) raises `mem_req` in the cycle after `start`, with `mem_addr` = sign-extended displacement and `done`=0. Both signals hold until `mem_ack` is sampled high. In the next cycle `done`=1, `mem_req`=0 and `ea` = `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one address computation |
| mode | input | 4 | Addressing-mode code |
| ra | input | RW | Primary register number |
| rb | input | RW | Secondary register number |
| disp | input | DW | Signed displacement / location / immediate |
| pc | input | AW | Program counter of the instruction |
| opsize | input | 2 | Operand size code |
| rfa_sel | output | RW | Register-file read port A select |
| rfa_val | input | AW | Register-file read port A data |
| rfb_sel | output | RW | Register-file read port B select |
| rfb_val | input | AW | Register-file read port B data |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | RW | Pointer write-back register |
| wb_val | output | AW | Pointer write-back value |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | AW | Pointer read location |
| mem_ack | input | 1 | Pointer read acknowledge |
| mem_rdata | input | AW | Pointer read data |
| ea | output | AW | Effective address or immediate value |
| kind | output | 2 | 0 address, 1 immediate, 2 register number |
| done | output | 1 | Result valid pulse |

## Verification
The bench uses displacements with the top bit set, such as 0x8000 and 0xFFFC. A design that zero-extends them would return an address about 64 K too high and would leave PC-relative branches pointing forward. Post-increment and pre-decrement are run with each size code. A design that added before reading, or read before subtracting, would return an address that differs from the expected one by exactly the step. A step not scaled by size would give the same write-back value for every size code. Memory indirect is held with the acknowledge low for several cycles while a new `start` is offered. A design that dropped the request, moved its address, or accepted the new command would show an early `done` or a wrong `ea`.

// File: rtl/eagen_pkg.sv
`timescale 1ns/1ps
package eagen_pkg;
  typedef enum logic [3:0] {
    AM_IMM   = 4'd0,
    AM_REG   = 4'd1,
    AM_ABS   = 4'd2,
    AM_RIND  = 4'd3,
    AM_MIND  = 4'd4,
    AM_IDX   = 4'd5,
    AM_BIDX  = 4'd6,
    AM_BIDXO = 4'd7,
    AM_PCREL = 4'd8,
    AM_AINC  = 4'd9,
    AM_ADEC  = 4'd10
  } am_e;

  typedef enum logic [1:0] {
    EK_MEM = 2'd0,
    EK_IMM = 2'd1,
    EK_REG = 2'd2
  } ek_e;
endpackage

// File: rtl/eag_sext.sv
`timescale 1ns/1ps
module eag_sext #(
  parameter int IW = 16,
  parameter int OW = 32
) (
  input  logic [IW-1:0] din,
  output logic [OW-1:0] dout
);
  generate
    if (OW > IW) begin : g_ext
      assign dout = {{(OW-IW){din[IW-1]}}, din};
    end else begin : g_cut
      assign dout = din[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/eag_calc.sv
`timescale 1ns/1ps
module eag_calc
  import eagen_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic [3:0]    mode,
  input  logic [RW-1:0] ra,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] vb,
  input  logic [AW-1:0] dx,
  input  logic [AW-1:0] pc,
  input  logic [1:0]    opsize,
  output logic [AW-1:0] ea,
  output logic [1:0]    kind,
  output logic          wb,
  output logic [AW-1:0] wbv,
  output logic          needs_mem
);
  logic [AW-1:0] step;
  logic [AW-1:0] post;
  logic [AW-1:0] pre;

  always_comb begin
    step = '0;
    case (opsize)
      2'd0:    step[2:0] = 3'd1;
      2'd1:    step[2:0] = 3'd2;
      default: step[2:0] = 3'd4;
    endcase
  end

  assign post = va + step;
  assign pre  = va - step;

  always_comb begin
    ea        = '0;
    kind      = EK_MEM;
    wb        = 1'b0;
    wbv       = post;
    needs_mem = 1'b0;
    case (mode)
      AM_IMM:   begin ea = dx; kind = EK_IMM; end
      AM_REG:   begin ea = {{(AW-RW){1'b0}}, ra}; kind = EK_REG; end
      AM_ABS:   ea = dx;
      AM_RIND:  ea = va;
      AM_MIND:  needs_mem = 1'b1;
      AM_IDX:   ea = dx + va;
      AM_BIDX:  ea = va + vb;
      AM_BIDXO: ea = dx + va + vb;
      AM_PCREL: ea = pc + dx;
      AM_AINC:  begin ea = va; wb = 1'b1; wbv = post; end
      AM_ADEC:  begin ea = pre; wb = 1'b1; wbv = pre; end
      default:  ea = '0;
    endcase
  end
endmodule

// File: rtl/eag_seq.sv
`timescale 1ns/1ps
module eag_seq
  import eagen_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          needs_mem,
  input  logic [AW-1:0] c_ea,
  input  logic [1:0]    c_kind,
  input  logic          c_wb,
  input  logic [AW-1:0] c_wbv,
  input  logic [RW-1:0] ra,
  input  logic [AW-1:0] dx,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic [AW-1:0] ea,
  output logic [1:0]    kind,
  output logic          done,
  output logic          wb_en,
  output logic [RW-1:0] wb_sel,
  output logic [AW-1:0] wb_val,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ea       <= '0;
      kind     <= EK_MEM;
      done     <= 1'b0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      wb_val   <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (needs_mem) begin
              mem_req  <= 1'b1;
              mem_addr <= dx;
              st       <= ST_WAIT;
            end else begin
              ea     <= c_ea;
              kind   <= c_kind;
              done   <= 1'b1;
              wb_en  <= c_wb;
              wb_sel <= ra;
              wb_val <= c_wbv;
            end
          end
        end
        default: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            ea      <= mem_rdata;
            kind    <= EK_MEM;
            done    <= 1'b1;
            st      <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eagen_top.sv
`timescale 1ns/1ps
module eagen_top #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [RW-1:0] ra,
  input  logic [RW-1:0] rb,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] pc,
  input  logic [1:0]    opsize,
  output logic [RW-1:0] rfa_sel,
  input  logic [AW-1:0] rfa_val,
  output logic [RW-1:0] rfb_sel,
  input  logic [AW-1:0] rfb_val,
  output logic          wb_en,
  output logic [RW-1:0] wb_sel,
  output logic [AW-1:0] wb_val,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic [AW-1:0] ea,
  output logic [1:0]    kind,
  output logic          done
);
  logic [AW-1:0] dx;
  logic [AW-1:0] c_ea;
  logic [1:0]    c_kind;
  logic          c_wb;
  logic [AW-1:0] c_wbv;
  logic          c_mem;

  assign rfa_sel = ra;
  assign rfb_sel = rb;

  eag_sext #(.IW(DW), .OW(AW)) u_sext (.din(disp), .dout(dx));

  eag_calc #(.AW(AW), .RW(RW)) u_calc (
    .mode(mode), .ra(ra), .va(rfa_val), .vb(rfb_val), .dx(dx), .pc(pc),
    .opsize(opsize), .ea(c_ea), .kind(c_kind), .wb(c_wb), .wbv(c_wbv),
    .needs_mem(c_mem)
  );

  eag_seq #(.AW(AW), .RW(RW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .needs_mem(c_mem),
    .c_ea(c_ea), .c_kind(c_kind), .c_wb(c_wb), .c_wbv(c_wbv),
    .ra(ra), .dx(dx), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ea(ea), .kind(kind), .done(done), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_val(wb_val), .mem_req(mem_req), .mem_addr(mem_addr)
  );
endmodule

// File: rtl/eagen_chk.sv
`timescale 1ns/1ps
module eagen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    mode,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          wb_en
);
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode != 4'd4) |=> done); // R2

  AST_MIND_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode == 4'd4) |=> (mem_req && !done)); // R12

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && !done)); // R12

  AST_ACK_FINISH: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (done && !mem_req)); // R12

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done); // R11

  AST_WB_PTR_MODES: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && (mode == 4'd9 || mode == 4'd10)) |=> wb_en); // R11

  AST_NO_WB_OTHER: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode != 4'd9 && mode != 4'd10) |=> !wb_en); // R11
endmodule

bind eagen_top eagen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .done(done), .wb_en(wb_en)
);

// File: tb/sim_eagen_top.sv
`timescale 1ns/1ps
module sim_eagen_top;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [RW-1:0] ra = '0, rb = '0;
  logic [DW-1:0] disp = '0;
  logic [AW-1:0] pc = '0;
  logic [1:0] opsize = '0;
  logic [RW-1:0] rfa_sel, rfb_sel, wb_sel;
  logic [AW-1:0] rfa_val, rfb_val, wb_val, mem_addr, ea;
  logic mem_ack = 1'b0;
  logic [AW-1:0] mem_rdata = '0;
  logic wb_en, mem_req, done;
  logic [1:0] kind;
  logic [AW-1:0] rf [16];
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  assign rfa_val = rf[rfa_sel];
  assign rfb_val = rf[rfb_sel];

  eagen_top #(.AW(AW), .DW(DW), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .ra(ra), .rb(rb),
    .disp(disp), .pc(pc), .opsize(opsize), .rfa_sel(rfa_sel),
    .rfa_val(rfa_val), .rfb_sel(rfb_sel), .rfb_val(rfb_val),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ea(ea), .kind(kind), .done(done)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle command; checks the done cycle and the cycle after
  task automatic run1(input string tag, input logic [3:0] m, input logic [RW-1:0] a,
                      input logic [RW-1:0] b, input logic [DW-1:0] d, input logic [1:0] sz,
                      input logic [AW-1:0] exp_ea, input logic [1:0] exp_kind,
                      input logic exp_wb, input logic [AW-1:0] exp_wbv);
    @(negedge clk);
    mode = m; ra = a; rb = b; disp = d; opsize = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 done"}, {31'd0, done}, 32'd1);
    chk({tag, " ea"}, ea, exp_ea);
    chk({tag, " kind"}, {30'd0, kind}, {30'd0, exp_kind});
    chk({tag, " R11 wb_en"}, {31'd0, wb_en}, {31'd0, exp_wb});
    if (exp_wb) begin
      chk({tag, " R11 wb_sel"}, {28'd0, wb_sel}, {28'd0, a});
      chk({tag, " wb_val"}, wb_val, exp_wbv);
    end
    @(negedge clk);
    chk({tag, " R2 done pulse"}, {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 wb_en", {31'd0, wb_en}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 ea", ea, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after", {31'd0, done}, 32'd0);
    chk("R1 req after", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_simple;
    run1("R3 imm pos", 4'd0, 4'd0, 4'd0, 16'h1234, 2'd0, 32'h0000_1234, 2'd1, 1'b0, '0);
    run1("R4 reg", 4'd1, 4'd11, 4'd0, 16'h0, 2'd0, 32'd11, 2'd2, 1'b0, '0);
    run1("R5 abs", 4'd2, 4'd0, 4'd0, 16'h0400, 2'd0, 32'h0000_0400, 2'd0, 1'b0, '0);
    run1("R5 rind", 4'd3, 4'd7, 4'd0, 16'h0, 2'd0, rf[7], 2'd0, 1'b0, '0);
  endtask

  task automatic t_index;
    run1("R6 idx", 4'd5, 4'd2, 4'd0, 16'h0010, 2'd0, rf[2] + 32'h10, 2'd0, 1'b0, '0);
    run1("R6 bidx", 4'd6, 4'd3, 4'd9, 16'h0, 2'd0, rf[3] + rf[9], 2'd0, 1'b0, '0);
    run1("R6 bidxo", 4'd7, 4'd4, 4'd6, 16'h0008, 2'd0, rf[4] + rf[6] + 32'h8, 2'd0, 1'b0, '0);
  endtask

  task automatic t_pcrel;
    pc = 32'h0000_0400;
    run1("R7 pcrel back", 4'd8, 4'd0, 4'd0, 16'hFFF0, 2'd0, 32'h0000_03F0, 2'd0, 1'b0, '0);
    run1("R7 pcrel fwd", 4'd8, 4'd0, 4'd0, 16'h0020, 2'd0, 32'h0000_0420, 2'd0, 1'b0, '0);
  endtask

  task automatic t_sext;
    run1("R8 imm neg", 4'd0, 4'd0, 4'd0, 16'h8000, 2'd0, 32'hFFFF_8000, 2'd1, 1'b0, '0);
    run1("R8 idx neg", 4'd5, 4'd2, 4'd0, 16'hFFFC, 2'd0, rf[2] - 32'd4, 2'd0, 1'b0, '0);
    run1("R8 abs neg", 4'd2, 4'd0, 4'd0, 16'hFF00, 2'd0, 32'hFFFF_FF00, 2'd0, 1'b0, '0);
  endtask

  task automatic t_ainc;
    run1("R9 ainc b", 4'd9, 4'd3, 4'd0, 16'h0, 2'd0, rf[3], 2'd0, 1'b1, rf[3] + 32'd1);
    run1("R9 ainc h", 4'd9, 4'd3, 4'd0, 16'h0, 2'd1, rf[3], 2'd0, 1'b1, rf[3] + 32'd2);
    run1("R9 ainc w", 4'd9, 4'd3, 4'd0, 16'h0, 2'd2, rf[3], 2'd0, 1'b1, rf[3] + 32'd4);
    run1("R9 ainc c3", 4'd9, 4'd12, 4'd0, 16'h0, 2'd3, rf[12], 2'd0, 1'b1, rf[12] + 32'd4);
  endtask

  task automatic t_adec;
    run1("R10 adec b", 4'd10, 4'd5, 4'd0, 16'h0, 2'd0, rf[5] - 32'd1, 2'd0, 1'b1, rf[5] - 32'd1);
    run1("R10 adec h", 4'd10, 4'd5, 4'd0, 16'h0, 2'd1, rf[5] - 32'd2, 2'd0, 1'b1, rf[5] - 32'd2);
    run1("R10 adec w", 4'd10, 4'd5, 4'd0, 16'h0, 2'd2, rf[5] - 32'd4, 2'd0, 1'b1, rf[5] - 32'd4);
  endtask

  task automatic t_mind;
    @(negedge clk);
    mode = 4'd4; disp = 16'h8010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 req", {31'd0, mem_req}, 32'd1);
    chk("R12 addr", mem_addr, 32'hFFFF_8010);
    chk("R12 no done", {31'd0, done}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 req held", {31'd0, mem_req}, 32'd1);
      chk("R12 addr held", mem_addr, 32'hFFFF_8010);
    end
    // a new command while waiting must be ignored
    mode = 4'd0; disp = 16'h0055; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 ignored start", {31'd0, done}, 32'd0);
    chk("R2 ignored req", {31'd0, mem_req}, 32'd1);
    mem_ack = 1'b1; mem_rdata = 32'hCAFE_0100;
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = '0;
    chk("R12 done", {31'd0, done}, 32'd1);
    chk("R12 ea", ea, 32'hCAFE_0100);
    chk("R12 req drop", {31'd0, mem_req}, 32'd0);
    chk("R12 no wb", {31'd0, wb_en}, 32'd0);
    @(negedge clk);
    chk("R12 done pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h0000_1000 * (i + 1) + i;
    t_reset();
    t_simple();
    t_index();
    t_pcrel();
    t_sext();
    t_ainc();
    t_adec();
    t_mind();
    run1("R2 after mind", 4'd3, 4'd1, 4'd0, 16'h0, 2'd0, rf[1], 2'd0, 1'b0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule